// File: doc/BRIEF.md
# Threshold feature coordinate tagger

This streaming stage sits behind an edge-strength stage in an image pipeline. It takes one magnitude value per handshake, in raster order over a 64 by 64 frame. That frame is what remains of a 66 by 66 source image once the border is trimmed. For every accepted value the stage emits a pair of coordinate words. If the value is strictly greater than the threshold in force for the frame, the pair holds the position's row and column. Otherwise both words are zero, so zero serves as the "no feature" sentinel.

The stage keeps its own row and column counters and does not rely on side-band position information. It marks the first output of each frame with a start flag and the last output with an end flag. Both sides use a valid/ready handshake, so the stage can be chained between producers and consumers that run at different rates. The threshold input is captured when the first position of a frame is accepted. It then stays fixed until the next frame begins.

Top module: `feature_tagger`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `out_valid` is low. The first sample accepted after reset is treated as row 0, column 0.
- R2: A sample whose value is strictly greater than the frame threshold produces `out_row` equal to its row index and `out_col` equal to its column index.
- R3: A sample whose value is equal to or below the frame threshold produces `out_row` = 0 and `out_col` = 0.
- R4: Positions are counted column first. The column runs from 0 to COLS-1 and then returns to 0 while the row increments. After row ROWS-1, column COLS-1, the count returns to row 0, column 0.
- R5: `out_sof` is 1 exactly on the output for position (0,0). `out_eof` is 1 exactly on the output for position (ROWS-1, COLS-1). Both flags are 0 on every other output.
- R6: The value on `thresh` is sampled when position (0,0) is accepted, and that sample is used for the comparison of (0,0) itself. Changes to `thresh` at any other time have no effect until the next (0,0).
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and all output data and flags hold their values.
- R8: `in_ready` is 1 whenever the output register is empty or is being drained in the same cycle. A sample accepted on one clock edge appears at the outputs right after that edge.
- R9: A feature in row 0 produces `out_row` = 0 and its true column. It receives no special treatment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thresh | input | DATA_W | Threshold, captured at frame start |
| in_valid | input | 1 | Input sample available |
| in_ready | output | 1 | Stage can take a sample |
| in_data | input | DATA_W | Edge-strength value |
| out_valid | output | 1 | Output pair available |
| out_ready | input | 1 | Consumer takes the pair |
| out_row | output | ROW_W | Row index of a feature, else 0 |
| out_col | output | COL_W | Column index of a feature, else 0 |
| out_sof | output | 1 | First position of frame |
| out_eof | output | 1 | Last position of frame |

## Verification
Each result is due exactly one clock edge after its input handshake. It then stays visible until the output handshake that consumes it. The bench sets inputs on the falling edge and records which handshakes will fire on the next rising edge. On the following falling edge it moves its queue model forward and compares `out_valid` and the head entry against the ports, so every cycle is checked, including stalled ones. The ready rule depends on the same cycle's `out_ready`, so it is checked right after the inputs settle.

// File: rtl/feature_tagger.sv
module feature_tagger #(
  parameter int DATA_W = 12,
  parameter int ROWS   = 64,
  parameter int COLS   = 64,
  localparam int ROW_W = $clog2(ROWS),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ROW_W-1:0]  out_row,
  output logic [COL_W-1:0]  out_col,
  output logic              out_sof,
  output logic              out_eof
);

  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] thr_q;

  wire accept   = in_valid && in_ready;
  wire at_start = (row_q == '0) && (col_q == '0);
  wire last_col = (col_q == COL_W'(COLS-1));
  wire last_row = (row_q == ROW_W'(ROWS-1));
  wire [DATA_W-1:0] thr_eff = at_start ? thresh : thr_q;
  wire hit = in_data > thr_eff;

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q     <= '0;
      col_q     <= '0;
      thr_q     <= '0;
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
    end else if (accept) begin
      if (at_start) thr_q <= thresh;
      col_q     <= last_col ? '0 : col_q + 1'b1;
      if (last_col) row_q <= last_row ? '0 : row_q + 1'b1;
      out_valid <= 1'b1;
      out_row   <= hit ? row_q : '0;
      out_col   <= hit ? col_q : '0;
      out_sof   <= at_start;
      out_eof   <= last_col && last_row;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_row, out_col, out_sof, out_eof}));

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_sof_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_sof |-> out_row == '0 && out_col == '0 && !out_eof);

  p_eof_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_eof |-> (out_row == ROW_W'(ROWS-1) && out_col == COL_W'(COLS-1))
                          || (out_row == '0 && out_col == '0));

  p_col_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !last_col |=> col_q == $past(col_q) + 1'b1 && row_q == $past(row_q));

  p_row_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && last_col && !last_row |=> col_q == '0 && row_q == $past(row_q) + 1'b1);

  p_thr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && at_start) |=> $stable(thr_q));

  p_idle_r1: assert property (@(posedge clk) $rose(rst_n) |-> !out_valid);

endmodule

// File: tb/feature_tagger_test.sv
module feature_tagger_test;
  localparam int DW = 12, NR = 64, NC = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [DW-1:0] thresh = '0, in_data = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic in_ready, out_valid, out_sof, out_eof;
  logic [5:0] out_row, out_col;

  always #4 clk = ~clk;

  feature_tagger #(.DATA_W(DW), .ROWS(NR), .COLS(NC)) uut (
    .clk(clk), .rst_n(rst_n), .thresh(thresh), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_row(out_row),
    .out_col(out_col), .out_sof(out_sof), .out_eof(out_eof));

  int checks = 0, fails = 0;
  int qr[$], qc[$], qs[$], qe[$];
  string qt[$];
  int mrow = 0, mcol = 0, mthr = 0, sent = 0;
  bit fire_in = 0, fire_out = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_sample(int d, int t);
    bit feat;
    string tag;
    if (mrow == 0 && mcol == 0) mthr = t;
    feat = d > mthr;
    if (mrow == 0 && mcol == 0) tag = "R5 sof";
    else if (mrow == NR-1 && mcol == NC-1) tag = "R5 eof";
    else if (t != mthr) tag = "R6 mid-frame threshold ignored";
    else if (feat && mrow == 0) tag = "R9 row-zero feature";
    else if (feat) tag = "R2 R4 feature coordinates";
    else tag = "R3 non-feature zero";
    qr.push_back(feat ? mrow : 0);
    qc.push_back(feat ? mcol : 0);
    qs.push_back(mrow == 0 && mcol == 0);
    qe.push_back(mrow == NR-1 && mcol == NC-1);
    qt.push_back(tag);
    if (mcol == NC-1) begin
      mcol = 0;
      mrow = (mrow == NR-1) ? 0 : mrow + 1;
    end else mcol++;
  endtask

  initial begin
    int cyc = 0;
    bit done = 0;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low in reset", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 valid low after reset", out_valid, 0);
    while (!done) begin
      if (fire_out) begin
        qr.pop_front(); qc.pop_front(); qs.pop_front(); qe.pop_front(); qt.pop_front();
      end
      if (fire_in) push_sample(in_data, thresh);
      chk(out_valid == (qr.size() != 0), "R8 R7 valid occupancy", out_valid, qr.size() != 0);
      if (out_valid && qr.size() != 0) begin
        chk(out_row == qr[0], {qt[0], " row"}, out_row, qr[0]);
        chk(out_col == qc[0], {qt[0], " col"}, out_col, qc[0]);
        chk(out_sof == qs[0] && out_eof == qe[0], {qt[0], " flags"},
            {out_sof, out_eof}, {qs[0][0], qe[0][0]});
      end
      if (sent < 3*NR*NC) begin
        int r = $urandom_range(0, 3);
        in_valid = ($urandom_range(0, 3) != 0);
        if (sent < NR*NC/2) thresh = 100;
        else if (sent < 2*NR*NC) thresh = 3000;
        else if (sent < 5*NR*NC/2) thresh = 500;
        else thresh = 1200;
        if (r == 0) in_data = DW'(mthr);
        else if (r == 1) in_data = DW'(mthr + 1);
        else if (r == 2) in_data = DW'(mthr == 0 ? 0 : mthr - 1);
        else in_data = DW'($urandom_range(0, 4095));
        if (mrow == 0 && mcol == 0) in_data = DW'(thresh + 1);
      end else in_valid = 1'b0;
      out_ready = ((cyc % 500) > 440) ? 1'b0 : ($urandom_range(0, 9) < 7);
      #1;
      chk(in_ready == (!out_valid || out_ready), "R8 ready rule", in_ready, !out_valid || out_ready);
      fire_in = in_valid && in_ready;
      fire_out = out_valid && out_ready;
      if (fire_in) sent++;
      cyc++;
      if (sent >= 3*NR*NC && qr.size() == 0 && !fire_in && !out_valid) done = 1;
      if (cyc > 190000) begin
        chk(1'b0, "watchdog", cyc, 0);
        done = 1;
      end
      @(negedge clk);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule